// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block builds the 8-bit status byte of a bus-attached instrument from six single-bit summary levels. Bit 0 is unused, and bit 6 is reserved for the service indication. A host-programmable enable register selects which summary bits may call for service. When any enabled summary bit is true, the master summary status is asserted.

A small two-state machine keeps a sticky request-for-service flag and drives the SRQ line from it. The flag is raised when the master summary rises. A serial poll clears it.

There are two read views. The query view is continuous and carries the master summary in bit 6. The poll view carries the request flag in bit 6. The machine states are `RQS_IDLE` (no request outstanding) and `RQS_PENDING` (request outstanding, SRQ driven). The machine has two transitions:

- `RQS_IDLE` to `RQS_PENDING` happens on a rising edge of the master summary.
- `RQS_PENDING` to `RQS_IDLE` happens on a poll strobe, but only in a cycle in which the master summary is not rising.

Top module: `status_byte_srq`

## Requirements
- R1: `query_o` places the summaries as follows: bit 7 = error queue not empty, bit 5 = event summary, bit 4 = message available, bit 3 = hardware summary, bit 2 = coupling summary, bit 1 = instrument summary, bit 0 = always 0.
- R2: An `en_wr_i` strobe loads `en_wdata_i` into the enable register, which is visible on `en_rdata_o` the next cycle. Bit 6 is always stored and read as 0. Without a strobe, the register holds its value.
- R3: `mss_o` is 1 exactly when the AND of the status byte (bits 7, 5..0) with the enable register is nonzero. `query_o[6]` equals `mss_o`.
- R4: A 0-to-1 change of `mss_o` sets `rqs_o` on the following clock. `srq_o` equals `rqs_o` at all times.
- R5: `poll_data_o` equals the status byte with bit 6 replaced by the current `rqs_o`. A cycle with `poll_i` high clears `rqs_o` at the next clock.
- R6: If a rising edge of `mss_o` occurs in the same cycle as a poll, the request is kept: `rqs_o` is 1 after that clock.
- R7: While `mss_o` stays high after a poll, no new request is raised. A new request needs `mss_o` to fall and then rise again.
- R8: Reset clears the enable register, `rqs_o` and `srq_o`.
- R9: A poll while no request is outstanding leaves `rqs_o` at 0 and returns bit 6 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_sum_i | input | 1 | Instrument status group summary |
| cpl_sum_i | input | 1 | Coupling status group summary |
| hw_sum_i | input | 1 | Hardware status group summary |
| mav_i | input | 1 | Output buffer holds response data |
| esb_i | input | 1 | Standard event status summary |
| errq_i | input | 1 | Error queue not empty |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| en_rdata_o | output | 8 | Enable register read-back |
| query_o | output | 8 | Query view of the status byte (bit 6 = master summary) |
| poll_i | input | 1 | Serial-poll strobe |
| poll_data_o | output | 8 | Poll view of the status byte (bit 6 = request flag) |
| mss_o | output | 1 | Master summary status |
| rqs_o | output | 1 | Request-for-service flag |
| srq_o | output | 1 | Service request line |

## Verification
The checker checks on every cycle the properties that hold cycle by cycle:

- bit 0 reads zero on both views;
- bit 6 of each view matches the master summary or the flag;
- the enable register reflects the last write with bit 6 masked;
- SRQ follows the flag;
- the flag sets after each master-summary rise, clears after a poll without a rise, and otherwise holds.

Only the bench scenarios can show three other things. The first is that the bit placement of each summary input is correct. The second is that a master summary held high through a poll raises no second request until it falls and rises again. The third is that a reset in the middle of a run drops a pending request.

// File: rtl/stb_pkg.sv
package stb_pkg;
    localparam int STB_W    = 8;
    localparam int BIT_INST = 1;
    localparam int BIT_CPL  = 2;
    localparam int BIT_HW   = 3;
    localparam int BIT_MAV  = 4;
    localparam int BIT_ESB  = 5;
    localparam int BIT_RQS  = 6;
    localparam int BIT_ERRQ = 7;
    // enable bits that may take part in the master summary
    localparam logic [STB_W-1:0] EN_MASK = ~(STB_W'(1) << BIT_RQS);

    typedef enum logic [0:0] {
        RQS_IDLE    = 1'b0,
        RQS_PENDING = 1'b1
    } rqs_state_e;
endpackage

// File: rtl/stb_assemble.sv
module stb_assemble
    import stb_pkg::*;
(
    input  logic             inst_i,
    input  logic             cpl_i,
    input  logic             hw_i,
    input  logic             mav_i,
    input  logic             esb_i,
    input  logic             errq_i,
    output logic [STB_W-1:0] sum_byte_o
);
    always_comb begin
        sum_byte_o           = '0;
        sum_byte_o[BIT_INST] = inst_i;
        sum_byte_o[BIT_CPL]  = cpl_i;
        sum_byte_o[BIT_HW]   = hw_i;
        sum_byte_o[BIT_MAV]  = mav_i;
        sum_byte_o[BIT_ESB]  = esb_i;
        sum_byte_o[BIT_ERRQ] = errq_i;
    end
endmodule

// File: rtl/stb_enable_reg.sv
module stb_enable_reg
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [STB_W-1:0] wdata_i,
    output logic [STB_W-1:0] en_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= '0;
        end else if (wr_i) begin
            en_o <= wdata_i & EN_MASK;
        end
    end
endmodule

// File: rtl/stb_rqs_fsm.sv
module stb_rqs_fsm
    import stb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss_i,
    input  logic poll_i,
    output logic rqs_o
);
    rqs_state_e state_q, state_d;
    logic       mss_q;
    logic       mss_rise;

    assign mss_rise = mss_i & ~mss_q;

    // state register and edge-detect history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RQS_IDLE;
            mss_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mss_q   <= mss_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQS_IDLE: begin
                if (mss_rise) state_d = RQS_PENDING;
            end
            RQS_PENDING: begin
                if (poll_i && !mss_rise) state_d = RQS_IDLE;
            end
            default: state_d = RQS_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        rqs_o = (state_q == RQS_PENDING);
    end
endmodule

// File: rtl/status_byte_srq.sv
module status_byte_srq
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inst_sum_i,
    input  logic             cpl_sum_i,
    input  logic             hw_sum_i,
    input  logic             mav_i,
    input  logic             esb_i,
    input  logic             errq_i,
    input  logic             en_wr_i,
    input  logic [STB_W-1:0] en_wdata_i,
    output logic [STB_W-1:0] en_rdata_o,
    output logic [STB_W-1:0] query_o,
    input  logic             poll_i,
    output logic [STB_W-1:0] poll_data_o,
    output logic             mss_o,
    output logic             rqs_o,
    output logic             srq_o
);
    logic [STB_W-1:0] sum_byte;
    logic [STB_W-1:0] en_q;

    stb_assemble u_asm (
        .inst_i     (inst_sum_i),
        .cpl_i      (cpl_sum_i),
        .hw_i       (hw_sum_i),
        .mav_i      (mav_i),
        .esb_i      (esb_i),
        .errq_i     (errq_i),
        .sum_byte_o (sum_byte)
    );

    stb_enable_reg u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .en_o    (en_q)
    );

    assign mss_o = |(sum_byte & en_q & EN_MASK);

    stb_rqs_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .mss_i  (mss_o),
        .poll_i (poll_i),
        .rqs_o  (rqs_o)
    );

    always_comb begin
        en_rdata_o           = en_q;
        srq_o                = rqs_o;
        query_o              = sum_byte;
        query_o[BIT_RQS]     = mss_o;
        poll_data_o          = sum_byte;
        poll_data_o[BIT_RQS] = rqs_o;
    end
endmodule

// File: rtl/stb_srq_checker.sv
module stb_srq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       en_wr_i,
    input logic [7:0] en_wdata_i,
    input logic [7:0] en_rdata_o,
    input logic [7:0] query_o,
    input logic       poll_i,
    input logic [7:0] poll_data_o,
    input logic       mss_o,
    input logic       rqs_o,
    input logic       srq_o
);
    assert_bit0_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (query_o[0] == 1'b0) && (poll_data_o[0] == 1'b0));

    assert_en_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_rdata_o == ($past(en_wdata_i) & 8'hBF)));

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_wr_i |=> $stable(en_rdata_o));

    assert_query_mss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        query_o[6] == mss_o);

    assert_rise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mss_o) |=> rqs_o);

    assert_srq_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        srq_o == rqs_o);

    assert_poll_bit6_R5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_data_o[6] == rqs_o);

    assert_poll_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_i && !$rose(mss_o)) |=> !rqs_o);

    assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!poll_i && !$rose(mss_o)) |=> $stable(rqs_o));
endmodule

bind status_byte_srq stb_srq_checker i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_wr_i     (en_wr_i),
    .en_wdata_i  (en_wdata_i),
    .en_rdata_o  (en_rdata_o),
    .query_o     (query_o),
    .poll_i      (poll_i),
    .poll_data_o (poll_data_o),
    .mss_o       (mss_o),
    .rqs_o       (rqs_o),
    .srq_o       (srq_o)
);

// File: tb/test_status_byte_srq.sv
module test_status_byte_srq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inst_sum_i = 0, cpl_sum_i = 0, hw_sum_i = 0;
    logic       mav_i = 0, esb_i = 0, errq_i = 0;
    logic       en_wr_i = 0;
    logic [7:0] en_wdata_i = '0;
    logic [7:0] en_rdata_o, query_o, poll_data_o;
    logic       poll_i = 0;
    logic       mss_o, rqs_o, srq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    status_byte_srq i_status_byte_srq (
        .clk(clk), .rst_n(rst_n),
        .inst_sum_i(inst_sum_i), .cpl_sum_i(cpl_sum_i), .hw_sum_i(hw_sum_i),
        .mav_i(mav_i), .esb_i(esb_i), .errq_i(errq_i),
        .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
        .query_o(query_o), .poll_i(poll_i), .poll_data_o(poll_data_o),
        .mss_o(mss_o), .rqs_o(rqs_o), .srq_o(srq_o)
    );

    // {inputs errq,esb,mav,hw,cpl,inst [5:0], enable write [7:0], expected query [7:0]}
    localparam logic [21:0] VEC [8] = '{
        {6'b000000, 8'hFF, 8'h00},
        {6'b000001, 8'h02, 8'h42},
        {6'b100000, 8'h02, 8'h80},
        {6'b100000, 8'h80, 8'hC0},
        {6'b011000, 8'h00, 8'h30},
        {6'b011110, 8'h08, 8'h7C},
        {6'b111111, 8'h40, 8'hBE},
        {6'b000100, 8'h01, 8'h08}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic set_in(input logic [5:0] v);
        {errq_i, esb_i, mav_i, hw_sum_i, cpl_sum_i, inst_sum_i} = v;
    endtask

    task automatic wr_en(input logic [7:0] d);
        en_wr_i = 1'b1; en_wdata_i = d;
        step();
        en_wr_i = 1'b0;
    endtask

    task automatic do_poll();
        poll_i = 1'b1;
        step();
        poll_i = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R8 reset state
        chk("R8 enable", en_rdata_o, 8'h00);
        chk("R8 rqs/srq", {6'b0, rqs_o, srq_o}, 8'h00);
        chk("R8 query", query_o, 8'h00);

        // R1 R2 R3 vector walk
        for (int i = 0; i < 8; i++) begin
            set_in(VEC[i][21:16]);
            wr_en(VEC[i][15:8]);
            chk("R2 readback", en_rdata_o, VEC[i][15:8] & 8'hBF);
            chk("R1 R3 query", query_o, VEC[i][7:0]);
            chk("R3 mss", {7'b0, mss_o}, {7'b0, VEC[i][6]});
            do_poll(); step();
        end

        // back to quiet
        set_in(6'b0); wr_en(8'h02); step(); do_poll(); step();
        chk("R9 idle rqs", {7'b0, rqs_o}, 8'h00);
        // R9 poll while idle
        poll_i = 1'b1; #1;
        chk("R9 poll bit6", poll_data_o, 8'h00);
        step(); poll_i = 1'b0;
        chk("R9 rqs stays", {7'b0, rqs_o}, 8'h00);

        // R4 rising mss sets flag next clock
        inst_sum_i = 1'b1; #1;
        chk("R3 mss comb", {7'b0, mss_o}, 8'h01);
        chk("R4 not yet", {6'b0, rqs_o, srq_o}, 8'h00);
        step();
        chk("R4 set", {6'b0, rqs_o, srq_o}, 8'h03);
        step(); step();
        chk("R2 hold", en_rdata_o, 8'h02);

        // R5 poll returns flag and clears it
        poll_i = 1'b1; #1;
        chk("R5 poll data", poll_data_o, 8'h42);
        step(); poll_i = 1'b0;
        chk("R5 cleared", {6'b0, rqs_o, srq_o}, 8'h00);
        chk("R5 query keeps mss", query_o, 8'h42);

        // R7 mss held high: no new request
        step(); step(); step();
        chk("R7 no re-request", {7'b0, rqs_o}, 8'h00);
        inst_sum_i = 1'b0; step();
        inst_sum_i = 1'b1; step();
        chk("R7 new request", {7'b0, rqs_o}, 8'h01);

        // R6 rise coincides with poll
        do_poll(); inst_sum_i = 1'b0; step();
        chk("R6 pre idle", {7'b0, rqs_o}, 8'h00);
        inst_sum_i = 1'b1; poll_i = 1'b1; #1;
        chk("R6 poll bit6 old", poll_data_o, 8'h02);
        step(); poll_i = 1'b0;
        chk("R6 request kept", {7'b0, rqs_o}, 8'h01);

        // R8 reset mid-run
        rst_n = 1'b0; step(); rst_n = 1'b1; inst_sum_i = 1'b0; #1;
        chk("R8 mid reset rqs", {6'b0, rqs_o, srq_o}, 8'h00);
        chk("R8 mid reset en", en_rdata_o, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule